// File: doc/BRIEF.md
# Shared-Bus Request Issue Controller

This block decides, cycle by cycle, whether one agent on a shared multi-agent system bus may place its next transaction request on the bus. Requests wait in a small in-order queue, and the head leaves the queue only when four conditions all hold:

- the agent holds the rotating arbitration turn;
- the shared stall line was not active at its last sampling slot;
- no priority agent is claiming the bus, unless a locked sequence is already under way;
- no bus initialization is being observed.

Configuration bits are captured while reset is held. They choose whether the agent drives bus initialization, whether it obeys bus initialization, and under which conditions it raises a bus error. Bus initialization clears only protocol state: the queue, the lock tracking, the rotating turn and the stall slot counter. No other storage is affected.

Top module: `bus_issue_ctl`

## Requirements
- R1: When reset is released, the following hold: `req_ready`=1, `iss_stb`=0, `arb_id`=0, `stall_slot`=1, `bus_init_out`=0 and `bus_err_out`=0.
- R2: The queue holds up to DEPTH requests. `req_ready` is low while it is full, and a request offered then is dropped. Requests issue in arrival order, at most one per cycle, each marked by a single-cycle `iss_stb` with its data and flags on `iss_data`/`iss_lock`/`iss_unlock`.
- R3: `arb_id` advances by one modulo N_AGENTS at every clock edge where `own_chg` is 1. A request issues only while `arb_id` equals MY_ID.
- R4: `stall_slot` is 1 in the first cycle after reset and then every STALL_PERIOD cycles. `bus_stall` is sampled only at an edge that closes a cycle with `stall_slot`=1. While the sampled value is 1, nothing issues. A stall level outside a slot has no effect.
- R5: One cycle after `bus_prio` is seen at an edge, nothing issues unless a locked sequence is in progress. Issuing a request with `iss_lock`=1 opens a sequence. The sequence stays open through the request with `iss_unlock`=1, which also issues. A request that would open a new sequence is held like any other.
- R6: Once `bus_prio` is seen low at an edge, issuing resumes in the next cycle.
- R7: If the latched observe bit is 1, `bus_init_in` seen at an edge has two effects. In the following cycle, `req_ready` and `iss_stb` are 0. After that cycle, the queue is empty, the lock is cleared, `arb_id`=0 and `stall_slot`=1. If the observe bit is 0, `bus_init_in` has no effect.
- R8: `bus_init_out` equals the latched drive bit AND `prot_fault`, delayed by one cycle.
- R9: `bus_err_out` is a registered value, computed as en AND ((int AND `int_err`) OR (init AND `txn_err` AND `txn_mine`) OR (any AND `txn_err`)). The terms en, int, init and any are the latched `cfg_berr_*` bits.
- R10: The `cfg_*` inputs are captured only while `rst_n` is 0. Changing them afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also the configuration capture window |
| cfg_binit_drv | input | 1 | Enable driving bus initialization |
| cfg_binit_obs | input | 1 | Enable obeying bus initialization |
| cfg_berr_en | input | 1 | Global bus-error enable |
| cfg_berr_int | input | 1 | Report internal errors |
| cfg_berr_init | input | 1 | Report errors on own transactions |
| cfg_berr_any | input | 1 | Report errors on any transaction |
| req_valid | input | 1 | Request offered to the queue |
| req_ready | output | 1 | Queue accepts the offered request |
| req_data | input | REQ_W | Request payload |
| req_lock | input | 1 | Request opens a locked sequence |
| req_unlock | input | 1 | Request closes a locked sequence |
| iss_stb | output | 1 | Head request issued this cycle |
| iss_data | output | REQ_W | Payload of the head request |
| iss_lock | output | 1 | Lock flag of the head request |
| iss_unlock | output | 1 | Unlock flag of the head request |
| bus_stall | input | 1 | Shared stall line (OR of all agents) |
| stall_slot | output | 1 | Current cycle ends on a stall sampling edge |
| bus_prio | input | 1 | Priority agent claims the bus |
| own_chg | input | 1 | Bus ownership passes to the next agent |
| arb_id | output | $clog2(N_AGENTS) | Agent holding the rotating turn |
| bus_init_in | input | 1 | Bus initialization seen on the bus |
| prot_fault | input | 1 | Condition that makes further bus traffic unreliable |
| bus_init_out | output | 1 | Drive bus initialization |
| int_err | input | 1 | Internal error |
| txn_err | input | 1 | Error seen on a bus transaction |
| txn_mine | input | 1 | The erroneous transaction was issued by this agent |
| bus_err_out | output | 1 | Drive bus error |

## Verification
The properties take the request flags as well formed: an unlock only ever follows a lock. They also assume `own_chg` does not arrive together with an observed bus initialization. The stimulus builds every locked sequence as a lock request, then plain requests, then an unlock request. It raises `own_chg` only in cycles without initialization. It changes `bus_stall` only at negative edges, which are aligned to the `stall_slot` output. The error-report sweep covers all sixteen option settings against all eight error input patterns.

// File: rtl/bus_issue_ctl.sv
module bus_issue_ctl #(
  parameter int N_AGENTS     = 4,
  parameter int MY_ID        = 0,
  parameter int DEPTH        = 4,
  parameter int REQ_W        = 8,
  parameter int STALL_PERIOD = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_binit_drv,
  input  logic                        cfg_binit_obs,
  input  logic                        cfg_berr_en,
  input  logic                        cfg_berr_int,
  input  logic                        cfg_berr_init,
  input  logic                        cfg_berr_any,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [REQ_W-1:0]            req_data,
  input  logic                        req_lock,
  input  logic                        req_unlock,
  output logic                        iss_stb,
  output logic [REQ_W-1:0]            iss_data,
  output logic                        iss_lock,
  output logic                        iss_unlock,
  input  logic                        bus_stall,
  output logic                        stall_slot,
  input  logic                        bus_prio,
  input  logic                        own_chg,
  output logic [$clog2(N_AGENTS)-1:0] arb_id,
  input  logic                        bus_init_in,
  input  logic                        prot_fault,
  output logic                        bus_init_out,
  input  logic                        int_err,
  input  logic                        txn_err,
  input  logic                        txn_mine,
  output logic                        bus_err_out
);
  localparam int IDW = $clog2(N_AGENTS);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int PW  = (STALL_PERIOD > 1) ? $clog2(STALL_PERIOD) : 1;
  localparam int EW  = REQ_W + 2;

  logic drv_en, obs_en, e_en, e_int, e_init, e_any;
  always_ff @(posedge clk)
    if (!rst_n) begin
      drv_en <= cfg_binit_drv;
      obs_en <= cfg_binit_obs;
      e_en   <= cfg_berr_en;
      e_int  <= cfg_berr_int;
      e_init <= cfg_berr_init;
      e_any  <= cfg_berr_any;
    end

  logic stall_q, prio_q, binit_q;
  logic flush;
  assign flush = obs_en & binit_q;

  logic [PW-1:0] ph;
  assign stall_slot = (ph == '0);

  always_ff @(posedge clk)
    if (!rst_n || flush)                   ph <= '0;
    else if (ph == PW'(STALL_PERIOD - 1))  ph <= '0;
    else                                   ph <= ph + PW'(1);

  always_ff @(posedge clk)
    if (!rst_n) begin
      stall_q <= 1'b0;
      prio_q  <= 1'b0;
      binit_q <= 1'b0;
    end else begin
      prio_q  <= bus_prio;
      binit_q <= bus_init_in;
      if (flush)           stall_q <= 1'b0;
      else if (stall_slot) stall_q <= bus_stall;
    end

  logic [IDW-1:0] arb_q;
  assign arb_id = arb_q;

  always_ff @(posedge clk)
    if (!rst_n || flush) arb_q <= '0;
    else if (own_chg)    arb_q <= (arb_q == IDW'(N_AGENTS - 1)) ? '0 : arb_q + IDW'(1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          locked;
  logic          owner, push;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign owner     = (arb_q == IDW'(MY_ID));
  assign req_ready = (cnt != CW'(DEPTH)) && !flush;
  assign push      = req_valid && req_ready;
  assign {iss_unlock, iss_lock, iss_data} = mem[rp];
  assign iss_stb   = (cnt != '0) && owner && !stall_q && (!prio_q || locked) && !flush;

  always_ff @(posedge clk)
    if (push) mem[wp] <= {req_unlock, req_lock, req_data};

  always_ff @(posedge clk)
    if (!rst_n || flush) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      locked <= 1'b0;
    end else begin
      if (push) wp <= nxt(wp);
      if (iss_stb) begin
        rp <= nxt(rp);
        if (iss_unlock)    locked <= 1'b0;
        else if (iss_lock) locked <= 1'b1;
      end
      case ({push, iss_stb})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      bus_init_out <= 1'b0;
      bus_err_out  <= 1'b0;
    end else begin
      bus_init_out <= drv_en & prot_fault;
      bus_err_out  <= e_en & ((e_int & int_err) | (e_init & txn_err & txn_mine) | (e_any & txn_err));
    end
endmodule

// File: rtl/bus_issue_ctl_chk.sv
module bus_issue_ctl_chk #(
  parameter int N_AGENTS = 4,
  parameter int MY_ID    = 0,
  parameter int DEPTH    = 4,
  parameter int IDW      = 2,
  parameter int CW       = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           iss_stb,
  input logic           iss_lock,
  input logic           iss_unlock,
  input logic           bus_stall,
  input logic           stall_slot,
  input logic           bus_prio,
  input logic           own_chg,
  input logic [IDW-1:0] arb_id,
  input logic           bus_init_in,
  input logic           prot_fault,
  input logic           bus_init_out,
  input logic           int_err,
  input logic           txn_err,
  input logic           txn_mine,
  input logic           bus_err_out,
  input logic           locked,
  input logic           obs_en,
  input logic           drv_en,
  input logic           flush,
  input logic [CW-1:0]  cnt,
  input logic           e_en,
  input logic           e_int,
  input logic           e_init,
  input logic           e_any
);
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  assert_push_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !iss_stb) |=> (cnt == $past(cnt) + CW'(1)));

  assert_owner_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_stb |-> (arb_id == IDW'(MY_ID)));

  assert_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (own_chg && !flush) |=>
      (arb_id == (($past(arb_id) == IDW'(N_AGENTS - 1)) ? IDW'(0) : $past(arb_id) + IDW'(1))));

  assert_stall_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_slot && bus_stall) |=> !iss_stb);

  assert_prio_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_prio && !locked && !(iss_stb && iss_lock && !iss_unlock)) |=> !iss_stb);

  assert_binit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_init_in && obs_en) |=> (!iss_stb && !req_ready) ##1 (arb_id == IDW'(0) && stall_slot));

  assert_binit_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bus_init_out == $past(drv_en && prot_fault)));

  assert_berr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bus_err_out ==
      $past(e_en && ((e_int && int_err) || (e_init && txn_err && txn_mine) || (e_any && txn_err)))));
endmodule

bind bus_issue_ctl bus_issue_ctl_chk #(
  .N_AGENTS(N_AGENTS), .MY_ID(MY_ID), .DEPTH(DEPTH), .IDW(IDW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .iss_stb(iss_stb), .iss_lock(iss_lock), .iss_unlock(iss_unlock),
  .bus_stall(bus_stall), .stall_slot(stall_slot), .bus_prio(bus_prio),
  .own_chg(own_chg), .arb_id(arb_id), .bus_init_in(bus_init_in),
  .prot_fault(prot_fault), .bus_init_out(bus_init_out), .int_err(int_err),
  .txn_err(txn_err), .txn_mine(txn_mine), .bus_err_out(bus_err_out),
  .locked(locked), .obs_en(obs_en), .drv_en(drv_en), .flush(flush), .cnt(cnt),
  .e_en(e_en), .e_int(e_int), .e_init(e_init), .e_any(e_any)
);

// File: tb/sim_bus_issue_ctl.sv
`timescale 1ns/1ps
module sim_bus_issue_ctl;
  localparam int NA = 4;
  localparam int P  = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic c_drv = 0, c_obs = 0, c_en = 0, c_int = 0, c_init = 0, c_any = 0;
  logic req_valid = 0, req_lock = 0, req_unlock = 0;
  logic [7:0] req_data = '0;
  logic bus_stall = 0, bus_prio = 0, own_chg = 0, bus_init_in = 0, prot_fault = 0;
  logic int_err = 0, txn_err = 0, txn_mine = 0;
  logic req_ready, iss_stb, iss_lock, iss_unlock, stall_slot, bus_init_out, bus_err_out;
  logic [7:0] iss_data;
  logic [1:0] arb_id;

  int total = 0, fails = 0;
  bit done = 0;

  bus_issue_ctl #(.N_AGENTS(NA), .MY_ID(0), .DEPTH(4), .REQ_W(8), .STALL_PERIOD(P)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_binit_drv(c_drv), .cfg_binit_obs(c_obs), .cfg_berr_en(c_en),
    .cfg_berr_int(c_int), .cfg_berr_init(c_init), .cfg_berr_any(c_any),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data),
    .req_lock(req_lock), .req_unlock(req_unlock),
    .iss_stb(iss_stb), .iss_data(iss_data), .iss_lock(iss_lock), .iss_unlock(iss_unlock),
    .bus_stall(bus_stall), .stall_slot(stall_slot), .bus_prio(bus_prio),
    .own_chg(own_chg), .arb_id(arb_id), .bus_init_in(bus_init_in),
    .prot_fault(prot_fault), .bus_init_out(bus_init_out),
    .int_err(int_err), .txn_err(txn_err), .txn_mine(txn_mine), .bus_err_out(bus_err_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic nx;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [5:0] cfg);
    @(negedge clk);
    rst_n = 1'b0;
    {c_drv, c_obs, c_en, c_int, c_init, c_any} = cfg;
    nx; nx;
    rst_n = 1'b1;
    {c_drv, c_obs, c_en, c_int, c_init, c_any} = ~cfg;
  endtask

  task automatic rotate(input int n);
    for (int i = 0; i < n; i++) begin own_chg = 1'b1; nx; end
    own_chg = 1'b0;
  endtask

  task automatic offer(input logic [7:0] d, input logic lk, input logic ul);
    req_valid = 1'b1; req_data = d; req_lock = lk; req_unlock = ul;
    #0.5;
    chk("R2 ready while not full", req_ready, 1);
    nx;
    req_valid = 1'b0; req_lock = 1'b0; req_unlock = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    // R1 reset state and R4 slot cadence
    do_reset(6'b000000);
    #0.5;
    chk("R1 ready", req_ready, 1);
    chk("R1 stb", iss_stb, 0);
    chk("R1 arb", arb_id, 0);
    chk("R1 slot", stall_slot, 1);
    chk("R1 init_out", bus_init_out, 0);
    chk("R1 err_out", bus_err_out, 0);
    for (int k = 0; k < 6; k++) begin
      chk("R4 slot cadence", stall_slot, (k % P) == 0);
      nx;
    end

    // R3 rotation sweep
    for (int k = 1; k <= 2 * NA; k++) begin
      own_chg = 1'b1; nx;
      chk("R3 arb advance", arb_id, k % NA);
    end
    own_chg = 1'b0;

    // R2 fill while not owner, overflow drop, in-order drain
    rotate(1);
    chk("R3 arb one", arb_id, 1);
    for (int i = 0; i < 4; i++) offer(8'h10 + 8'(i), 1'b0, 1'b0);
    req_valid = 1'b1; req_data = 8'h99;
    #0.5;
    chk("R2 full not ready", req_ready, 0);
    chk("R3 no issue off turn", iss_stb, 0);
    nx;
    req_valid = 1'b0;
    rotate(3);
    for (int i = 0; i < 4; i++) begin
      chk("R2 issue strobe", iss_stb, 1);
      chk("R2 issue order", iss_data, 8'h10 + i);
      nx;
    end
    chk("R2 overflow dropped", iss_stb, 0);

    // R4 stall held from one slot to the next
    while (!stall_slot) nx;
    bus_stall = 1'b1; req_valid = 1'b1; req_data = 8'h21;
    nx;
    bus_stall = 1'b0; req_valid = 1'b0;
    chk("R4 stalled", iss_stb, 0);
    nx;
    chk("R4 held between slots", iss_stb, 0);
    nx;
    chk("R4 release strobe", iss_stb, 1);
    chk("R4 release data", iss_data, 8'h21);
    nx;
    chk("R4 drained", iss_stb, 0);
    // R4 stall outside a slot ignored
    while (stall_slot) nx;
    bus_stall = 1'b1; req_valid = 1'b1; req_data = 8'h22;
    nx;
    bus_stall = 1'b0; req_valid = 1'b0;
    chk("R4 off-slot ignored", iss_stb, 1);
    chk("R4 off-slot data", iss_data, 8'h22);
    nx;
    chk("R4 drained again", iss_stb, 0);

    // R5 locked sequence rides through priority, R6 resume
    rotate(1);
    offer(8'h31, 1'b1, 1'b0);
    offer(8'h32, 1'b0, 1'b0);
    offer(8'h33, 1'b0, 1'b1);
    offer(8'h34, 1'b1, 1'b1);
    rotate(3);
    chk("R5 lock start", iss_stb, 1);
    chk("R5 lock start data", iss_data, 8'h31);
    bus_prio = 1'b1;
    nx;
    chk("R5 locked continues", iss_stb, 1);
    chk("R5 locked data", iss_data, 8'h32);
    nx;
    chk("R5 unlock issues", iss_stb, 1);
    chk("R5 unlock data", iss_data, 8'h33);
    nx;
    chk("R5 new lock held", iss_stb, 0);
    nx;
    chk("R5 still held", iss_stb, 0);
    bus_prio = 1'b0;
    nx;
    chk("R6 resume", iss_stb, 1);
    chk("R6 resume data", iss_data, 8'h34);
    nx;
    chk("R6 drained", iss_stb, 0);

    // R7 observed bus init, R8 drive, R10 capture only in reset
    do_reset(6'b110000);
    rotate(2);
    offer(8'h41, 1'b0, 1'b0);
    offer(8'h42, 1'b0, 1'b0);
    offer(8'h43, 1'b0, 1'b0);
    bus_init_in = 1'b1;
    nx;
    bus_init_in = 1'b0;
    req_valid = 1'b1; req_data = 8'h4F;
    #0.5;
    chk("R7 ready low", req_ready, 0);
    chk("R7 no issue", iss_stb, 0);
    nx;
    req_valid = 1'b0;
    chk("R7 arb cleared", arb_id, 0);
    chk("R7 slot restart", stall_slot, 1);
    chk("R7 queue discarded", iss_stb, 0);
    offer(8'h44, 1'b0, 1'b0);
    chk("R7 fresh issue", iss_stb, 1);
    chk("R7 fresh data", iss_data, 8'h44);
    nx;
    prot_fault = 1'b1;
    nx;
    chk("R8 R10 drive on", bus_init_out, 1);
    prot_fault = 1'b0;
    nx;
    chk("R8 drive off", bus_init_out, 0);

    // R7 observe disabled, R8 drive disabled, R10
    do_reset(6'b000000);
    rotate(1);
    offer(8'h51, 1'b0, 1'b0);
    offer(8'h52, 1'b0, 1'b0);
    bus_init_in = 1'b1;
    nx;
    bus_init_in = 1'b0;
    #0.5;
    chk("R7 R10 unobserved ready", req_ready, 1);
    nx;
    chk("R7 unobserved arb", arb_id, 1);
    prot_fault = 1'b1;
    nx;
    chk("R8 R10 drive disabled", bus_init_out, 0);
    prot_fault = 1'b0;
    rotate(3);
    chk("R7 kept first", iss_data, 8'h51);
    chk("R7 kept strobe", iss_stb, 1);
    nx;
    chk("R7 kept second", iss_data, 8'h52);
    nx;

    // R9 R10 error report sweep
    for (int c = 0; c < 16; c++) begin
      do_reset({2'b00, 4'(c)});
      for (int v = 0; v < 8; v++) begin
        {int_err, txn_err, txn_mine} = 3'(v);
        nx;
        chk("R9 R10 bus error", bus_err_out,
            c[3] & ((c[2] & v[2]) | (c[1] & v[1] & v[0]) | (c[0] & v[1])));
      end
      {int_err, txn_err, txn_mine} = 3'b000;
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule